// File: doc/BRIEF.md
# Base and Bound Address Translator

This block relocates and range-checks addresses for a processor that uses plain segment registers instead of paging. It holds two independent segments, each with a base and a length. The program segment serves instruction fetch, driven by the program counter. The data segment serves loads and stores, driven by the effective address. For each request the block adds the segment base to the incoming address to form a physical address. It raises a violation when the address does not lie inside the segment length.

Both translations are purely combinational and may run in the same cycle. The four segment registers are written through one configuration port. That port accepts writes only while the processor is in supervisor mode. A write tried in user mode is dropped and reported with a one-cycle privilege-error pulse. A request that violates its bound never produces a valid physical address, so the memory system sees no access for it.

Top module: `seg_xlate`

## Requirements
- R1: After reset both bases and both lengths are zero. Any request then flags a violation, and priv_err_o is low.
- R2: When a request is in range, its physical address is the segment base plus the zero-extended address, taken modulo 2^PA_W. It appears in the same cycle as the request.
- R3: An address is in range only when it is strictly less than the segment length. An address equal to or above the length raises the violation output.
- R4: Fetch requests use only the program base and length. Data requests use only the data base and length. Writing one segment never changes the results of the other.
- R5: In supervisor mode a write with cfg_we_i high updates the register picked by cfg_sel_i: 0 program base, 1 program length, 2 data base, 3 data length. The new value governs translations from the next cycle on.
- R6: A write attempted with sup_mode_i low changes no register. priv_err_o is high for exactly the cycle after each such attempt, and low after any other cycle.
- R7: The valid output is high only when a request is present and in range. Without a request both the valid and the violation outputs are low.
- R8: Fetch and data translations in the same cycle do not interfere. Each side's outputs depend only on its own request and segment.
- R9: A length register takes the low VA_W+1 bits of the write data. A length of 2^VA_W admits every address, including the all-ones address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sup_mode_i | input | 1 | Processor is in supervisor mode |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_sel_i | input | 2 | Register select (see R5) |
| cfg_wdata_i | input | PA_W | Write data |
| priv_err_o | output | 1 | Pulse after a user-mode write attempt |
| if_req_i | input | 1 | Fetch translation request |
| if_pc_i | input | VA_W | Program counter |
| if_pa_o | output | PA_W | Fetch physical address |
| if_pa_valid_o | output | 1 | Fetch physical address valid |
| if_viol_o | output | 1 | Fetch bounds violation |
| dt_req_i | input | 1 | Data translation request |
| dt_ea_i | input | VA_W | Effective address |
| dt_pa_o | output | PA_W | Data physical address |
| dt_pa_valid_o | output | 1 | Data physical address valid |
| dt_viol_o | output | 1 | Data bounds violation |

## Verification
The bench builds the block with VA_W = 8 and PA_W = 12. With these values a length of 256 (the R9 full-space case) and the all-ones address 0xFF can be reached directly. The same values let a base near the top of the 4 KiB physical space show the modulo wrap of R2. With such small widths, the boundary addresses on both sides of each length are exact and cheap to drive. Both sides are driven together with differing segments to expose any cross-coupling.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned NUM_SEG = 2;
  localparam int unsigned SEG_W   = 1;

  typedef enum logic [SEG_W-1:0] {
    SEG_PROG = 1'b0,
    SEG_DATA = 1'b1
  } seg_id_e;

  // cfg_sel_i[1] picks the segment, cfg_sel_i[0] picks base (0) or length (1)
  typedef enum logic [1:0] {
    CFG_PROG_BASE = 2'd0,
    CFG_PROG_LEN  = 2'd1,
    CFG_DATA_BASE = 2'd2,
    CFG_DATA_LEN  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/seg_priv_gate.sv
module seg_priv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic sup_mode_i,
  output logic wr_en_o,
  output logic priv_err_o
);
  logic err_q;

  assign wr_en_o = cfg_we_i & sup_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= cfg_we_i & ~sup_mode_i;
  end

  assign priv_err_o = err_q;
endmodule

// File: rtl/seg_reg_bank.sv
module seg_reg_bank
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W  = 20,
  parameter int unsigned LEN_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEG_W-1:0]  wr_seg_i,
  input  logic              wr_len_i,
  input  logic [PA_W-1:0]   wr_data_i,
  output logic [PA_W-1:0]   base_o [NUM_SEG],
  output logic [LEN_W-1:0]  len_o  [NUM_SEG]
);
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [PA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    logic             hit;

    assign hit = wr_en_i && (wr_seg_i == SEG_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q <= '0;
        len_q  <= '0;
      end else if (hit) begin
        if (wr_len_i) len_q  <= wr_data_i[LEN_W-1:0];
        else          base_q <= wr_data_i;
      end
    end

    assign base_o[s] = base_q;
    assign len_o[s]  = len_q;
  end
endmodule

// File: rtl/seg_xlate_path.sv
module seg_xlate_path #(
  parameter int unsigned VA_W  = 16,
  parameter int unsigned PA_W  = 20,
  parameter int unsigned LEN_W = 17
) (
  input  logic             req_i,
  input  logic [VA_W-1:0]  ea_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             pa_valid_o,
  output logic             viol_o
);
  logic in_range;

  assign in_range   = LEN_W'(ea_i) < len_i;
  assign pa_o       = base_i + PA_W'(ea_i);
  assign pa_valid_o = req_i & in_range;
  assign viol_o     = req_i & ~in_range;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sup_mode_i,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [PA_W-1:0] cfg_wdata_i,
  output logic            priv_err_o,
  input  logic            if_req_i,
  input  logic [VA_W-1:0] if_pc_i,
  output logic [PA_W-1:0] if_pa_o,
  output logic            if_pa_valid_o,
  output logic            if_viol_o,
  input  logic            dt_req_i,
  input  logic [VA_W-1:0] dt_ea_i,
  output logic [PA_W-1:0] dt_pa_o,
  output logic            dt_pa_valid_o,
  output logic            dt_viol_o
);
  // length must reach 2^VA_W; PA_W must be at least VA_W+1
  localparam int unsigned LEN_W = VA_W + 1;

  logic             wr_en;
  logic [PA_W-1:0]  base_w [NUM_SEG];
  logic [LEN_W-1:0] len_w  [NUM_SEG];

  logic             req_w   [NUM_SEG];
  logic [VA_W-1:0]  addr_w  [NUM_SEG];
  logic [PA_W-1:0]  pa_w    [NUM_SEG];
  logic             valid_w [NUM_SEG];
  logic             viol_w  [NUM_SEG];

  seg_priv_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .sup_mode_i (sup_mode_i),
    .wr_en_o    (wr_en),
    .priv_err_o (priv_err_o)
  );

  seg_reg_bank #(.PA_W(PA_W), .LEN_W(LEN_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_seg_i  (cfg_sel_i[1]),
    .wr_len_i  (cfg_sel_i[0]),
    .wr_data_i (cfg_wdata_i),
    .base_o    (base_w),
    .len_o     (len_w)
  );

  assign req_w[SEG_PROG]  = if_req_i;
  assign addr_w[SEG_PROG] = if_pc_i;
  assign req_w[SEG_DATA]  = dt_req_i;
  assign addr_w[SEG_DATA] = dt_ea_i;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_path
    seg_xlate_path #(.VA_W(VA_W), .PA_W(PA_W), .LEN_W(LEN_W)) u_path (
      .req_i      (req_w[s]),
      .ea_i       (addr_w[s]),
      .base_i     (base_w[s]),
      .len_i      (len_w[s]),
      .pa_o       (pa_w[s]),
      .pa_valid_o (valid_w[s]),
      .viol_o     (viol_w[s])
    );
  end

  assign if_pa_o       = pa_w[SEG_PROG];
  assign if_pa_valid_o = valid_w[SEG_PROG];
  assign if_viol_o     = viol_w[SEG_PROG];
  assign dt_pa_o       = pa_w[SEG_DATA];
  assign dt_pa_valid_o = valid_w[SEG_DATA];
  assign dt_viol_o     = viol_w[SEG_DATA];
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned VA_W = 16,
  parameter int unsigned PA_W = 20
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sup_mode_i,
  input logic            cfg_we_i,
  input logic [1:0]      cfg_sel_i,
  input logic [PA_W-1:0] cfg_wdata_i,
  input logic            priv_err_o,
  input logic            if_req_i,
  input logic [VA_W-1:0] if_pc_i,
  input logic [PA_W-1:0] if_pa_o,
  input logic            if_pa_valid_o,
  input logic            if_viol_o,
  input logic            dt_req_i,
  input logic [VA_W-1:0] dt_ea_i,
  input logic [PA_W-1:0] dt_pa_o,
  input logic            dt_pa_valid_o,
  input logic            dt_viol_o,
  input logic [PA_W-1:0] prog_base_i,
  input logic [VA_W:0]   prog_len_i,
  input logic [PA_W-1:0] data_base_i
);
  p_if_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(if_pa_valid_o && if_viol_o));
  p_dt_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dt_pa_valid_o && dt_viol_o));
  p_if_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_req_i |-> (!if_pa_valid_o && !if_viol_o));
  p_dt_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dt_req_i |-> (!dt_pa_valid_o && !dt_viol_o));
  p_if_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_pa_valid_o |-> (if_pa_o == PA_W'(prog_base_i + PA_W'(if_pc_i))));
  p_dt_sum_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_pa_valid_o |-> (dt_pa_o == PA_W'(data_base_i + PA_W'(dt_ea_i))));
  p_if_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_req_i && ({1'b0, if_pc_i} >= prog_len_i)) |-> if_viol_o);
  p_priv_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !sup_mode_i) |=> priv_err_o);
  p_priv_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && !sup_mode_i) |=> !priv_err_o);
  p_user_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !sup_mode_i) |=> ($stable(prog_base_i) && $stable(prog_len_i) && $stable(data_base_i)));
  p_sup_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && sup_mode_i && cfg_sel_i == 2'd0) |=> (prog_base_i == $past(cfg_wdata_i)));
endmodule

bind seg_xlate seg_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sup_mode_i    (sup_mode_i),
  .cfg_we_i      (cfg_we_i),
  .cfg_sel_i     (cfg_sel_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .priv_err_o    (priv_err_o),
  .if_req_i      (if_req_i),
  .if_pc_i       (if_pc_i),
  .if_pa_o       (if_pa_o),
  .if_pa_valid_o (if_pa_valid_o),
  .if_viol_o     (if_viol_o),
  .dt_req_i      (dt_req_i),
  .dt_ea_i       (dt_ea_i),
  .dt_pa_o       (dt_pa_o),
  .dt_pa_valid_o (dt_pa_valid_o),
  .dt_viol_o     (dt_viol_o),
  .prog_base_i   (base_w[0]),
  .prog_len_i    (len_w[0]),
  .data_base_i   (base_w[1])
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int unsigned VA_W = 8;
  localparam int unsigned PA_W = 12;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            sup_mode_i = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic [1:0]      cfg_sel_i = '0;
  logic [PA_W-1:0] cfg_wdata_i = '0;
  logic            priv_err_o;
  logic            if_req_i = 1'b0;
  logic [VA_W-1:0] if_pc_i = '0;
  logic [PA_W-1:0] if_pa_o;
  logic            if_pa_valid_o, if_viol_o;
  logic            dt_req_i = 1'b0;
  logic [VA_W-1:0] dt_ea_i = '0;
  logic [PA_W-1:0] dt_pa_o;
  logic            dt_pa_valid_o, dt_viol_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) dut_i (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(bit sup, logic [1:0] sel, int data);
    @(negedge clk_i);
    sup_mode_i = sup; cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = PA_W'(data);
    @(negedge clk_i);
    cfg_we_i = 1'b0; sup_mode_i = 1'b0;
  endtask

  task automatic drive(bit ir, int pc, bit dr, int ea);
    if_req_i = ir; if_pc_i = VA_W'(pc); dt_req_i = dr; dt_ea_i = VA_W'(ea);
    #1;
  endtask

  task automatic t_reset;
    drive(1, 0, 1, 0);
    chk("R1", "fetch viol after reset", int'(if_viol_o), 1);
    chk("R1", "data viol after reset", int'(dt_viol_o), 1);
    chk("R1", "fetch valid after reset", int'(if_pa_valid_o), 0);
    chk("R1", "priv_err after reset", int'(priv_err_o), 0);
  endtask

  task automatic t_fetch_bounds;
    cfg_write(1, 2'd0, 'h100);
    chk("R5", "no priv_err on supervisor write", int'(priv_err_o), 0);
    cfg_write(1, 2'd1, 'h40);
    drive(1, 'h10, 0, 0);
    chk("R2", "fetch pa", int'(if_pa_o), 'h110);
    chk("R5", "fetch valid after writes", int'(if_pa_valid_o), 1);
    drive(1, 'h3F, 0, 0);
    chk("R3", "last in-range valid", int'(if_pa_valid_o), 1);
    chk("R2", "last in-range pa", int'(if_pa_o), 'h13F);
    drive(1, 'h40, 0, 0);
    chk("R3", "equal to length viol", int'(if_viol_o), 1);
    chk("R7", "equal to length valid low", int'(if_pa_valid_o), 0);
    drive(1, 'h41, 0, 0);
    chk("R3", "above length viol", int'(if_viol_o), 1);
  endtask

  task automatic t_separation;
    cfg_write(1, 2'd2, 'h800);
    cfg_write(1, 2'd3, 'h20);
    drive(1, 'h05, 1, 'h05);
    chk("R4", "fetch pa uses program base", int'(if_pa_o), 'h105);
    chk("R8", "data pa same cycle", int'(dt_pa_o), 'h805);
    chk("R8", "both valid", int'({if_pa_valid_o, dt_pa_valid_o}), 3);
    drive(1, 'h30, 1, 'h30);
    chk("R4", "data length 0x20 viol", int'(dt_viol_o), 1);
    chk("R8", "fetch unaffected by data viol", int'(if_pa_valid_o), 1);
    chk("R8", "fetch pa 0x130", int'(if_pa_o), 'h130);
  endtask

  task automatic t_user_write;
    cfg_write(0, 2'd0, 'hABC);
    chk("R6", "priv_err after user write", int'(priv_err_o), 1);
    drive(1, 'h10, 0, 0);
    chk("R6", "program base unchanged", int'(if_pa_o), 'h110);
    cfg_write(0, 2'd3, 'hFF);
    chk("R6", "priv_err second attempt", int'(priv_err_o), 1);
    drive(0, 0, 1, 'h30);
    chk("R6", "data length unchanged", int'(dt_viol_o), 1);
    @(negedge clk_i);
    chk("R6", "priv_err drops", int'(priv_err_o), 0);
  endtask

  task automatic t_full_wrap;
    cfg_write(1, 2'd1, 'h100);
    cfg_write(1, 2'd0, 'hFF0);
    drive(1, 'hFF, 0, 0);
    chk("R9", "all-ones address in full length", int'(if_pa_valid_o), 1);
    chk("R2", "pa wraps modulo 2^PA_W", int'(if_pa_o), 'h0EF);
    cfg_write(1, 2'd1, 'hF00);
    drive(1, 0, 0, 0);
    chk("R9", "length takes low bits, 0x100", int'(if_pa_valid_o), 1);
  endtask

  task automatic t_noreq;
    drive(0, 'h80, 0, 'h80);
    chk("R7", "no fetch req outputs low", int'({if_pa_valid_o, if_viol_o}), 0);
    chk("R7", "no data req outputs low", int'({dt_pa_valid_o, dt_viol_o}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fetch_bounds();
    t_separation();
    t_user_write();
    t_full_wrap();
    t_noreq();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule